// File: doc/BRIEF.md
# Packed Calendar Clock Counter

This block keeps wall-clock time for a chip as a calendar. The time of day and the date sit in one 32-bit word of bit-packed fields, and the year is a separate 16-bit register of four BCD digits. A one-second tick strobe advances the calendar while the run enable is high. Each step carries correctly through seconds, minutes, hours, the day of week, the day of month (the month length and the Gregorian leap-year rule apply), the month and the year.

Software sets the time through direct load ports, one for the time word and one for the year. Two match registers, one for the time word and one for the year, hold an alarm point. The block raises a one-cycle alarm pulse when a tick moves the calendar onto a value equal to both match registers. Reads are the plain `time_o` and `year_o` outputs. Bus decoding and interrupt masking are outside this block.

Top module: `cal_clock_core`

## Requirements
- R1: After a synchronous reset, `time_o` is 0x0212_0000 (Sunday the 1st of month 1, 00:00:00), `year_o` is 0x2000 and `alarm_o` is 0.
- R2: When `tick_i` or `run_i` is low and no load is asserted, `time_o` and `year_o` hold their values.
- R3: The time word has these fields: seconds in bits 5:0 (0..59), minutes in bits 11:6 (0..59) and hours in bits 16:12 (0..23). On an advancing tick the seconds count up. Each of these fields wraps to 0 past its limit and carries into the next field.
- R4: The day of week is in bits 19:17 (1..7, 1 = Sunday). It advances when the hours wrap past 23 and goes from 7 back to 1.
- R5: The day of month is in bits 24:20 and the month in bits 28:25 (1 = January). The day of month goes back to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days and month 2 has 28 days, or 29 in a leap year. A leap year is a multiple of 4 that is not a multiple of 100, or a multiple of 400, and the rule is evaluated on the BCD year.
- R6: After December 31 the month goes to 1 and the year increments in BCD. The low two digits are in bits 7:0 and the century digits in bits 15:8, and 9999 wraps to 0000.
- R7: A time load replaces the time word on the next edge, with bits 31:29 forced to 0. A year load replaces the year. Each load takes priority over a tick in the same cycle.
- R8: `alarm_o` is high for exactly the one cycle in which `time_o` and `year_o` first show a value produced by a tick that equals both match registers. It is never high after a cycle that asserted a load.
- R9: A match-register write is used by ticks from the next cycle onward. A tick in the same cycle as the write is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance strobe |
| run_i | input | 1 | Calendar counting enable |
| time_ld_i | input | 1 | Load strobe for the time word |
| time_ld_data_i | input | 32 | Packed time word to load |
| year_ld_i | input | 1 | Load strobe for the year |
| year_ld_data_i | input | 16 | BCD year to load |
| mt_we_i | input | 1 | Write strobe for the time match register |
| mt_data_i | input | 32 | Time match value |
| my_we_i | input | 1 | Write strobe for the year match register |
| my_data_i | input | 16 | BCD year match value |
| time_o | output | 32 | Current packed time word |
| year_o | output | 16 | Current BCD year |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The assertions check the cycle-local rules on every cycle:
- the time word holds when there is no advancing tick;
- the seconds count up by one with no other field disturbed;
- a load is captured with the pad bits cleared;
- the day of week wraps at midnight;
- an alarm pulse only follows a load-free tick and equals the previous match values.

Month lengths, leap and century years, the 9999 wrap and the match-write ordering depend on long carry chains. Only the bench's scenarios show these, with its calendar model checking each cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int TIME_W   = 32;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int WDAY_W   = 3;
  localparam int MDAY_W   = 5;
  localparam int MON_W    = 4;
  localparam int PAD_W    = TIME_W - SEC_W - MIN_W - HOUR_W - WDAY_W - MDAY_W - MON_W;
  localparam int DIGIT_W  = 4;

  typedef struct packed {
    logic [PAD_W-1:0]  pad;
    logic [MON_W-1:0]  mon;
    logic [MDAY_W-1:0] mday;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  // A two-digit BCD value is a multiple of 4 when an even tens digit pairs
  // with units 0/4/8, or an odd tens digit pairs with units 2/6.
  function automatic logic bcd2_div4(input logic [7:0] b);
    if (b[4]) return (b[3:0] == 4'd2) || (b[3:0] == 4'd6);
    else      return (b[3:0] == 4'd0) || (b[3:0] == 4'd4) || (b[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/cal_bcd_inc.sv
module cal_bcd_inc #(
  parameter int DIGITS = 4
) (
  input  logic [DIGITS*cal_pkg::DIGIT_W-1:0] val_i,
  output logic [DIGITS*cal_pkg::DIGIT_W-1:0] val_o
);
  localparam int DW = cal_pkg::DIGIT_W;
  logic [DIGITS:0] carry;
  assign carry[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [DW-1:0] dig;
    assign dig = val_i[d*DW +: DW];
    always_comb begin
      if (!carry[d])        val_o[d*DW +: DW] = dig;
      else if (dig >= 4'd9) val_o[d*DW +: DW] = '0;
      else                  val_o[d*DW +: DW] = dig + 4'd1;
    end
    assign carry[d+1] = carry[d] && (dig >= 4'd9);
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
  parameter int YEAR_W = 16
) (
  input  logic [cal_pkg::MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0]          year_i,
  output logic [cal_pkg::MDAY_W-1:0] days_o
);
  logic leap;
  logic [7:0] lo_pair;
  logic [7:0] hi_pair;

  assign lo_pair = year_i[7:0];
  assign hi_pair = year_i[15:8];
  assign leap = (lo_pair != 8'h00) ? cal_pkg::bcd2_div4(lo_pair)
                                   : cal_pkg::bcd2_div4(hi_pair);

  always_comb begin
    case (mon_i)
      4'd2:                      days_o = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   days_o = 5'd30;
      default:                   days_o = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_time_step.sv
module cal_time_step
  import cal_pkg::*;
(
  input  cal_time_t         cur_i,
  input  logic [MDAY_W-1:0] days_i,
  output cal_time_t         nxt_o,
  output logic              year_carry_o
);
  logic c_min, c_hour, c_day, c_mon;

  always_comb begin
    nxt_o  = cur_i;
    c_min  = cur_i.sec  >= 6'd59;
    c_hour = c_min  && (cur_i.min  >= 6'd59);
    c_day  = c_hour && (cur_i.hour >= 5'd23);
    c_mon  = c_day  && (cur_i.mday >= days_i);
    year_carry_o = c_mon && (cur_i.mon >= 4'd12);

    nxt_o.sec = c_min ? '0 : cur_i.sec + 6'd1;
    if (c_min)  nxt_o.min  = c_hour ? '0 : cur_i.min + 6'd1;
    if (c_hour) nxt_o.hour = c_day  ? '0 : cur_i.hour + 5'd1;
    if (c_day) begin
      nxt_o.wday = (cur_i.wday >= 3'd7) ? 3'd1 : cur_i.wday + 3'd1;
      nxt_o.mday = c_mon ? 5'd1 : cur_i.mday + 5'd1;
    end
    if (c_mon)  nxt_o.mon = year_carry_o ? 4'd1 : cur_i.mon + 4'd1;
  end
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int          YEAR_DIGITS = 4,
  parameter logic [31:0] RST_TIME    = 32'h0212_0000,
  parameter logic [15:0] RST_YEAR    = 16'h2000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        run_i,
  input  logic        time_ld_i,
  input  logic [31:0] time_ld_data_i,
  input  logic        year_ld_i,
  input  logic [15:0] year_ld_data_i,
  input  logic        mt_we_i,
  input  logic [31:0] mt_data_i,
  input  logic        my_we_i,
  input  logic [15:0] my_data_i,
  output logic [31:0] time_o,
  output logic [15:0] year_o,
  output logic        alarm_o
);
  localparam int YEAR_W = YEAR_DIGITS * DIGIT_W;
  localparam logic [TIME_W-1:0] LOAD_MASK = {{PAD_W{1'b0}}, {(TIME_W-PAD_W){1'b1}}};

  cal_time_t         time_r, match_t_r, nxt_t;
  logic [YEAR_W-1:0] year_r, match_y_r, year_inc, year_nxt;
  logic [MDAY_W-1:0] days;
  logic              ycarry, adv;

  assign adv      = tick_i && run_i;
  assign year_nxt = ycarry ? year_inc : year_r;

  cal_month_len #(.YEAR_W(YEAR_W)) u_len (
    .mon_i (time_r.mon),
    .year_i(year_r),
    .days_o(days)
  );

  cal_time_step u_step (
    .cur_i       (time_r),
    .days_i      (days),
    .nxt_o       (nxt_t),
    .year_carry_o(ycarry)
  );

  cal_bcd_inc #(.DIGITS(YEAR_DIGITS)) u_inc (
    .val_i(year_r),
    .val_o(year_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      time_r    <= cal_time_t'(RST_TIME);
      year_r    <= RST_YEAR[YEAR_W-1:0];
      match_t_r <= '1;
      match_y_r <= '1;
      alarm_o   <= 1'b0;
    end else begin
      if (mt_we_i) match_t_r <= cal_time_t'(mt_data_i);
      if (my_we_i) match_y_r <= my_data_i[YEAR_W-1:0];

      if (time_ld_i)  time_r <= cal_time_t'(time_ld_data_i & LOAD_MASK);
      else if (adv)   time_r <= nxt_t;

      if (year_ld_i)                   year_r <= year_ld_data_i[YEAR_W-1:0];
      else if (adv && !time_ld_i)      year_r <= year_nxt;

      alarm_o <= adv && !time_ld_i && !year_ld_i &&
                 (nxt_t == match_t_r) && (year_nxt == match_y_r);
    end
  end

  assign time_o = time_r;
  assign year_o = year_r;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick_i,
  input logic        run_i,
  input logic        time_ld_i,
  input logic [31:0] time_ld_data_i,
  input logic        year_ld_i,
  input logic [31:0] time_o,
  input logic [15:0] year_o,
  input logic        alarm_o,
  input logic [31:0] match_t,
  input logic [15:0] match_y
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!time_ld_i && !year_ld_i && !(tick_i && run_i)) |=> ($stable(time_o) && $stable(year_o)));

  p_sec_up_r3: assert property (@(posedge clk) disable iff (rst)
    (!time_ld_i && tick_i && run_i && time_o[5:0] < 6'd59) |=>
      (time_o[5:0] == $past(time_o[5:0]) + 6'd1) && (time_o[31:6] == $past(time_o[31:6])));

  p_wday_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!time_ld_i && tick_i && run_i && time_o[16:0] == {5'd23, 6'd59, 6'd59} &&
     time_o[19:17] == 3'd7) |=> (time_o[19:17] == 3'd1));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    time_ld_i |=> (time_o == ($past(time_ld_data_i) & 32'h1FFF_FFFF)));

  p_alarm_src_r8: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> $past(tick_i && run_i && !time_ld_i && !year_ld_i));

  p_alarm_eq_r9: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> (time_o == $past(match_t) && year_o == $past(match_y)));
endmodule

bind cal_clock_core cal_clock_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick_i        (tick_i),
  .run_i         (run_i),
  .time_ld_i     (time_ld_i),
  .time_ld_data_i(time_ld_data_i),
  .year_ld_i     (year_ld_i),
  .time_o        (time_o),
  .year_o        (year_o),
  .alarm_o       (alarm_o),
  .match_t       (match_t_r),
  .match_y       (match_y_r)
);

// File: tb/cal_clock_core_bench.sv
`timescale 1ns/1ps
module cal_clock_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 0, run_i = 0, time_ld_i = 0, year_ld_i = 0, mt_we_i = 0, my_we_i = 0;
  logic [31:0] time_ld_data_i = 0, mt_data_i = 0;
  logic [15:0] year_ld_data_i = 0, my_data_i = 0;
  logic [31:0] time_o;
  logic [15:0] year_o;
  logic        alarm_o;

  always #5 clk = ~clk;

  cal_clock_core u_cal_clock_core (.*);

  int checks = 0, errors = 0;
  bit started = 0, done = 0;
  string cur_req = "R1";

  // behavioural calendar model
  int m_s, m_mi, m_h, m_wd, m_md, m_mo, m_y;
  int mt_word, my_word;
  bit m_alarm;

  function automatic int to_bcd(input int v);
    return ((v / 1000) % 10) << 12 | ((v / 100) % 10) << 8 | ((v / 10) % 10) << 4 | (v % 10);
  endfunction
  function automatic int from_bcd(input int b);
    return ((b >> 12) & 15) * 1000 + ((b >> 8) & 15) * 100 + ((b >> 4) & 15) * 10 + (b & 15);
  endfunction
  function automatic int pk(input int mo, md, wd, h, mi, s);
    return (mo << 25) | (md << 20) | (wd << 17) | (h << 12) | (mi << 6) | s;
  endfunction
  function automatic int mlen(input int mo, y);
    bit leap;
    leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int m_word();
    return pk(m_mo, m_md, m_wd, m_h, m_mi, m_s);
  endfunction

  always @(posedge clk) begin
    bit carry;
    carry = 0;
    if (rst) begin
      m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_md = 1; m_mo = 1; m_y = 2000;
      mt_word = -1; my_word = 'hFFFF; m_alarm = 0;
    end else begin
      if (time_ld_i) begin
        m_s = time_ld_data_i[5:0]; m_mi = time_ld_data_i[11:6]; m_h = time_ld_data_i[16:12];
        m_wd = time_ld_data_i[19:17]; m_md = time_ld_data_i[24:20]; m_mo = time_ld_data_i[28:25];
      end else if (tick_i && run_i) begin
        m_s++;
        if (m_s == 60) begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_h++; end
        if (m_h == 24) begin
          m_h = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          m_md++;
          if (m_md > mlen(m_mo, m_y)) begin m_md = 1; m_mo++; end
          if (m_mo == 13) begin m_mo = 1; carry = 1; end
        end
      end
      if (year_ld_i) m_y = from_bcd(year_ld_data_i);
      else if (carry) m_y = (m_y + 1) % 10000;
      m_alarm = tick_i && run_i && !time_ld_i && !year_ld_i &&
                (m_word() == mt_word) && (to_bcd(m_y) == my_word);
      if (mt_we_i) mt_word = mt_data_i;
      if (my_we_i) my_word = my_data_i;
    end
  end

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("time", time_o, m_word());
    chk("year", year_o, to_bcd(m_y));
    chk("alarm", alarm_o, m_alarm);
  end

  task automatic ticks(input int n, input bit r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1; run_i = r;
      @(posedge clk); #1 tick_i = 0;
    end
  endtask
  task automatic idle(input int n, input bit tk, input bit r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = tk; run_i = r;
      @(posedge clk); #1 tick_i = 0;
    end
  endtask
  task automatic load(input int tw, input int yb, input bit tk);
    @(negedge clk); time_ld_i = 1; time_ld_data_i = tw; year_ld_i = 1; year_ld_data_i = yb[15:0];
    tick_i = tk; run_i = 1;
    @(posedge clk); #1 time_ld_i = 0; year_ld_i = 0; tick_i = 0;
  endtask
  task automatic set_match(input int tw, input int yb, input bit tk);
    @(negedge clk); mt_we_i = 1; mt_data_i = tw; my_we_i = 1; my_data_i = yb[15:0];
    tick_i = tk; run_i = 1;
    @(posedge clk); #1 mt_we_i = 0; my_we_i = 0; tick_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    started = 1;                      // R1: reset values checked while held
    @(negedge clk); rst = 0;
    idle(2, 0, 0);

    cur_req = "R2";                   // hold with run low or tick low
    idle(4, 1, 0);
    idle(4, 0, 1);

    cur_req = "R3";                   // second/minute/hour rollover
    load(pk(3, 10, 2, 22, 58, 57), 'h2021, 0);
    ticks(70, 1);
    ticks(3600, 1);

    cur_req = "R4";                   // weekday 7 -> 1 at midnight
    load(pk(5, 9, 7, 23, 59, 58), 'h2026, 0);
    ticks(4, 1);

    cur_req = "R5";                   // month lengths and leap rule
    load(pk(2, 28, 4, 23, 59, 59), 'h2024, 0); ticks(2, 1);
    load(pk(2, 29, 4, 23, 59, 59), 'h2024, 0); ticks(1, 1);
    load(pk(2, 28, 3, 23, 59, 59), 'h2023, 0); ticks(1, 1);
    load(pk(2, 28, 1, 23, 59, 59), 'h2100, 0); ticks(1, 1);
    load(pk(2, 28, 2, 23, 59, 59), 'h2000, 0); ticks(1, 1);
    load(pk(4, 30, 5, 23, 59, 59), 'h2022, 0); ticks(1, 1);
    load(pk(1, 30, 5, 23, 59, 59), 'h2022, 0); ticks(2, 1);

    cur_req = "R6";                   // year rollover and century carry
    load(pk(12, 31, 6, 23, 59, 59), 'h1999, 0); ticks(2, 1);
    load(pk(12, 31, 6, 23, 59, 59), 'h2099, 0); ticks(1, 1);
    load(pk(12, 31, 6, 23, 59, 59), 'h9999, 0); ticks(1, 1);

    cur_req = "R7";                   // load beats tick; pad bits cleared
    load(32'hE000_0000 | pk(12, 31, 6, 23, 59, 59), 'h2040, 1);
    idle(2, 0, 1);

    cur_req = "R8";                   // alarm on full match only
    load(pk(6, 15, 3, 10, 20, 30), 'h2030, 0);
    set_match(pk(6, 15, 3, 10, 20, 32), 'h2030, 0);
    ticks(4, 1);
    load(pk(6, 15, 3, 10, 20, 30), 'h2030, 0);
    set_match(pk(6, 15, 3, 10, 20, 32), 'h2031, 0);
    ticks(4, 1);
    set_match(pk(6, 15, 3, 10, 20, 40), 'h2030, 0);
    load(pk(6, 15, 3, 10, 20, 39), 'h2030, 1);   // load in place of matching tick
    idle(2, 0, 1);

    cur_req = "R9";                   // match write with simultaneous tick
    load(pk(6, 15, 3, 10, 20, 30), 'h2030, 0);
    set_match(pk(6, 15, 3, 10, 20, 31), 'h2030, 1);
    set_match(pk(6, 15, 3, 10, 20, 33), 'h2030, 1);
    ticks(3, 1);

    idle(2, 0, 0);
    finish_run();
  end
endmodule